// File: doc/BRIEF.md
# Coprocessor Access Permission Register

This block keeps the privileged control word that decides whether the two coupled coprocessor slots, number 10 (floating point) and number 11 (its companion slot), may be used. It also holds a switch that turns off SIMD instructions that are not floating-point operations. System software reads and writes the word through a simple request port. The port accepts a request only when the current privilege level is 1 or higher. Its response comes back registered, one cycle after the request.

A combinational checker sits beside the storage. For each instruction that the pipeline presents, it states whether an undefined-instruction exception is due. The checker takes the coprocessor number, the privilege level, a Hyp-mode flag, the Non-secure state, a per-slot Non-secure enable mask and an is-SIMD flag. Two build-time switches state whether the floating-point unit and the SIMD extension exist, and these fix which bits can be written. The Secure and Non-secure worlds share one copy of the word.

Top module: `cp_access_ctl`

## Requirements
- R1: After reset, both access fields hold 00 and the stored SIMD-disable bit is 0, so with both features present a privileged read returns 0x0000_0000. The response outputs are low until the first request.
- R2: Access code decoding. Slot 10 uses bits [21:20] and slot 11 uses bits [23:22]. Code 00 denies at every level. Code 01 allows access only at privilege level 1 or higher and denies at level 0. Code 11 allows access at every level.
- R3: Access code 10 is reserved and always denies.
- R4: Bit 31 is the SIMD-disable bit. When bit 31 reads 1 and is_simd is set, slot 10 or 11 raises undefined whatever the field allows. When bit 31 reads 0, the field alone decides.
- R5: With the floating-point unit present and the SIMD extension absent, bit 31 reads 1 and ignores writes. With neither feature present, bit 31 reads 0 and ignores writes.
- R6: With neither feature present, both access fields read 00 and ignore writes.
- R7: Bits 30 down to 24 and bits 19 down to 0 always read 0, and writes to them are discarded.
- R8: A request at privilege level 0 returns the error flag with read data 0, and the stored word does not change.
- R9: In Hyp mode the checker never signals undefined.
- R10: In Non-secure state, a write changes a field only when that field's mask bit is set (bit 0 for slot 10, bit 1 for slot 11). A read returns 00 for a field whose mask bit is clear. The checker treats such a field as code 00.
- R11: The checker signals undefined only for coprocessor numbers 10 and 11. Each slot is judged by its own field alone.
- R12: Every request is answered in the next cycle with ack high. A read returns the word as it stood at the request. A write returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_wdata | input | 32 | Write data |
| cur_pl | input | 2 | Current privilege level (0 = unprivileged) |
| cur_ns | input | 1 | Current state is Non-secure |
| ns_cp_en | input | 2 | Non-secure enable per slot (bit 0 slot 10, bit 1 slot 11) |
| reg_ack | output | 1 | Response valid, one cycle after request |
| reg_err | output | 1 | Request rejected for privilege |
| reg_rdata | output | 32 | Read data |
| chk_cp_num | input | 4 | Coprocessor number of the checked instruction |
| chk_hyp | input | 1 | Instruction executes in Hyp mode |
| chk_simd | input | 1 | Instruction is a SIMD non-floating-point operation |
| chk_undef | output | 1 | Undefined-instruction exception is due |

## Verification
The bench targets the reserved code 10. A decoder that treated it as 01 or 11 would let a level-1 instruction through. It writes different codes into the two slots, which catches a design that shares or swaps the fields. It checks that Hyp mode and other coprocessor numbers never flag, and that level-0 writes leave the word intact. It also runs Non-secure writes and reads with partial masks: a broken mask would leak a field or overwrite one that should be locked. Two extra instances, one with the floating-point unit only and one with neither feature, show whether the read-as-one and read-as-zero rules are held against writes.

// File: rtl/cp_access_pkg.sv
package cp_access_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_PRIV = 2'b01,
    ACC_RSVD = 2'b10,
    ACC_FULL = 2'b11
  } acc_code_e;

  localparam int NUM_CP    = 2;
  localparam int CP_BASE   = 10;
  localparam int FIELD_LSB = 20;
  localparam int SD_BIT    = 31;
  localparam int REG_W     = 32;
  localparam int PL_W      = 2;
  localparam int CPN_W     = 4;
endpackage

// File: rtl/cp_code_decode.sv
module cp_code_decode
  import cp_access_pkg::*;
#(
  parameter int PL_W_P = PL_W
) (
  input  logic [1:0]        code,
  input  logic [PL_W_P-1:0] pl,
  output logic              deny
);
  acc_code_e code_e;
  assign code_e = acc_code_e'(code);

  always_comb begin
    unique case (code_e)
      ACC_NONE: deny = 1'b1;
      ACC_PRIV: deny = (pl == '0);
      ACC_RSVD: deny = 1'b1;   // reserved: deterministic deny
      ACC_FULL: deny = 1'b0;
      default:  deny = 1'b1;
    endcase
  end
endmodule

// File: rtl/cp_perm_store.sv
module cp_perm_store
  import cp_access_pkg::*;
#(
  parameter bit HAS_FPU   = 1'b1,
  parameter bit HAS_SIMD  = 1'b1,
  parameter int N_CP      = NUM_CP,
  parameter int F_LSB     = FIELD_LSB,
  parameter int SDB       = SD_BIT,
  parameter int W         = REG_W,
  parameter int PW        = PL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  input  logic [PW-1:0]     pl,
  input  logic              ns,
  input  logic [N_CP-1:0]   ns_en,
  output logic              ack,
  output logic              err,
  output logic [W-1:0]      rdata,
  output logic [2*N_CP-1:0] fld_o,
  output logic              sd_o
);
  localparam bit FIELDS_LIVE = HAS_FPU || HAS_SIMD;
  localparam bit SD_LIVE     = HAS_SIMD;
  localparam bit SD_CONST    = HAS_FPU && !HAS_SIMD;
  localparam logic [W-1:0] LIVE_MASK =
    W'(((64'd1 << (2*N_CP)) - 64'd1) << F_LSB) | W'(64'd1 << SDB);

  logic [2*N_CP-1:0] fld_q;
  logic              sd_q;
  logic              priv_ok;
  logic [W-1:0]      rd_val;
  logic              sd_rd;

  assign priv_ok = req && (pl != '0);
  assign sd_rd   = SD_LIVE ? sd_q : SD_CONST;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q <= '0;
      sd_q  <= 1'b0;
    end else if (priv_ok && we) begin
      for (int i = 0; i < N_CP; i++) begin
        if (FIELDS_LIVE && (!ns || ns_en[i]))
          fld_q[2*i +: 2] <= wdata[F_LSB + 2*i +: 2];
      end
      if (SD_LIVE) sd_q <= wdata[SDB];
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_CP; i++)
      rd_val[F_LSB + 2*i +: 2] = (ns && !ns_en[i]) ? 2'b00 : fld_q[2*i +: 2];
    rd_val[SDB] = sd_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      err   <= req && (pl == '0);
      rdata <= (priv_ok && !we) ? rd_val : '0;
    end
  end

  assign fld_o = fld_q;
  assign sd_o  = sd_rd;

  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~LIVE_MASK);

  p_ack_next_r12: assert property (@(posedge clk) disable iff (rst)
    req |=> ack);
  p_pl0_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (req && pl == '0) |=> ($stable(fld_q) && err && rdata == '0));
  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ack |-> ((rdata & ~LIVE_MASK) == '0));

  for (genvar g = 0; g < N_CP; g++) begin : g_ns_chk
    p_ns_locked_r10: assert property (@(posedge clk) disable iff (rst)
      (req && we && ns && !ns_en[g]) |=> $stable(fld_q[2*g +: 2]));
  end
endmodule

// File: rtl/cp_perm_check.sv
module cp_perm_check
  import cp_access_pkg::*;
#(
  parameter int N_CP  = NUM_CP,
  parameter int BASE  = CP_BASE,
  parameter int CW    = CPN_W,
  parameter int PW    = PL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*N_CP-1:0] fld,
  input  logic              sd,
  input  logic [CW-1:0]     cp_num,
  input  logic [PW-1:0]     pl,
  input  logic              hyp,
  input  logic              ns,
  input  logic [N_CP-1:0]   ns_en,
  input  logic              is_simd,
  output logic              undef
);
  logic [N_CP-1:0] hit;
  logic [N_CP-1:0] deny;
  logic [N_CP-1:0] slot_undef;

  for (genvar g = 0; g < N_CP; g++) begin : g_slot
    logic [1:0] eff;
    assign eff = (ns && !ns_en[g]) ? 2'b00 : fld[2*g +: 2];
    assign hit[g] = (cp_num == CW'(BASE + g));

    cp_code_decode #(.PL_W_P(PW)) u_dec (
      .code (eff),
      .pl   (pl),
      .deny (deny[g])
    );

    assign slot_undef[g] = hit[g] && (deny[g] || (is_simd && sd));

    p_deny_none_r2: assert property (@(posedge clk) disable iff (rst)
      (hit[g] && !hyp && eff == 2'b00) |-> undef);
    p_rsvd_deny_r3: assert property (@(posedge clk) disable iff (rst)
      (hit[g] && !hyp && eff == 2'b10) |-> undef);
    p_simd_off_r4: assert property (@(posedge clk) disable iff (rst)
      (hit[g] && !hyp && is_simd && sd) |-> undef);
  end

  assign undef = !hyp && (|slot_undef);

  p_hyp_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    hyp |-> !undef);
  p_other_cp_r11: assert property (@(posedge clk) disable iff (rst)
    ($countones(hit) == 0) |-> !undef);
endmodule

// File: rtl/cp_access_ctl.sv
module cp_access_ctl
  import cp_access_pkg::*;
#(
  parameter bit HAS_FPU  = 1'b1,
  parameter bit HAS_SIMD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [PL_W-1:0]  cur_pl,
  input  logic             cur_ns,
  input  logic [NUM_CP-1:0] ns_cp_en,
  output logic             reg_ack,
  output logic             reg_err,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [CPN_W-1:0] chk_cp_num,
  input  logic             chk_hyp,
  input  logic             chk_simd,
  output logic             chk_undef
);
  logic [2*NUM_CP-1:0] fld;
  logic                sd;

  cp_perm_store #(
    .HAS_FPU (HAS_FPU),
    .HAS_SIMD(HAS_SIMD)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .req   (reg_req),
    .we    (reg_we),
    .wdata (reg_wdata),
    .pl    (cur_pl),
    .ns    (cur_ns),
    .ns_en (ns_cp_en),
    .ack   (reg_ack),
    .err   (reg_err),
    .rdata (reg_rdata),
    .fld_o (fld),
    .sd_o  (sd)
  );

  cp_perm_check u_check (
    .clk     (clk),
    .rst     (rst),
    .fld     (fld),
    .sd      (sd),
    .cp_num  (chk_cp_num),
    .pl      (cur_pl),
    .hyp     (chk_hyp),
    .ns      (cur_ns),
    .ns_en   (ns_cp_en),
    .is_simd (chk_simd),
    .undef   (chk_undef)
  );
endmodule

// File: tb/cp_access_ctl_tb_top.sv
`timescale 1ns/1ps
module cp_access_ctl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, req, we, ns, hyp, simd;
  logic [31:0] wdata;
  logic [1:0]  pl, ns_en;
  logic [3:0]  cpn;
  logic [31:0] rdata [3];
  logic        ack [3];
  logic        err [3];
  logic        undef [3];

  int total = 0;
  int bad   = 0;

  localparam bit HF [3] = '{1'b1, 1'b1, 1'b0};
  localparam bit HS [3] = '{1'b1, 1'b0, 1'b0};
  bit [1:0] mf [3][2];
  bit       msd [3];

  cp_access_ctl #(.HAS_FPU(1'b1), .HAS_SIMD(1'b1)) dut_i (
    .clk(clk), .rst(rst), .reg_req(req), .reg_we(we), .reg_wdata(wdata),
    .cur_pl(pl), .cur_ns(ns), .ns_cp_en(ns_en), .reg_ack(ack[0]),
    .reg_err(err[0]), .reg_rdata(rdata[0]), .chk_cp_num(cpn),
    .chk_hyp(hyp), .chk_simd(simd), .chk_undef(undef[0]));
  cp_access_ctl #(.HAS_FPU(1'b1), .HAS_SIMD(1'b0)) dut_fp_i (
    .clk(clk), .rst(rst), .reg_req(req), .reg_we(we), .reg_wdata(wdata),
    .cur_pl(pl), .cur_ns(ns), .ns_cp_en(ns_en), .reg_ack(ack[1]),
    .reg_err(err[1]), .reg_rdata(rdata[1]), .chk_cp_num(cpn),
    .chk_hyp(hyp), .chk_simd(simd), .chk_undef(undef[1]));
  cp_access_ctl #(.HAS_FPU(1'b0), .HAS_SIMD(1'b0)) dut_none_i (
    .clk(clk), .rst(rst), .reg_req(req), .reg_we(we), .reg_wdata(wdata),
    .cur_pl(pl), .cur_ns(ns), .ns_cp_en(ns_en), .reg_ack(ack[2]),
    .reg_err(err[2]), .reg_rdata(rdata[2]), .chk_cp_num(cpn),
    .chk_hyp(hyp), .chk_simd(simd), .chk_undef(undef[2]));

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit sd_read(int v);
    return HS[v] ? msd[v] : HF[v];
  endfunction

  function automatic bit [1:0] eff_fld(int v, int i);
    return (ns && !ns_en[i]) ? 2'b00 : mf[v][i];
  endfunction

  function automatic logic [31:0] exp_read(int v);
    logic [31:0] r = '0;
    r[21:20] = eff_fld(v, 0);
    r[23:22] = eff_fld(v, 1);
    r[31]    = sd_read(v);
    return r;
  endfunction

  function automatic bit exp_undef(int v);
    bit [1:0] c;
    bit dn;
    if (hyp) return 1'b0;
    if (cpn != 4'd10 && cpn != 4'd11) return 1'b0;
    c  = eff_fld(v, int'(cpn) - 10);
    dn = (c == 2'b00) || (c == 2'b10) || (c == 2'b01 && pl == 2'd0);
    return dn || (simd && sd_read(v));
  endfunction

  task automatic do_acc(bit w, logic [31:0] d, logic [1:0] p, bit n,
                        logic [1:0] e, string tag);
    logic [31:0] er [3];
    @(negedge clk);
    req = 1'b1; we = w; wdata = d; pl = p; ns = n; ns_en = e;
    for (int v = 0; v < 3; v++)
      er[v] = (p != 0 && !w) ? exp_read(v) : 32'd0;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int v = 0; v < 3; v++) begin
      check(ack[v] == 1'b1, "R12 ack", 32'(ack[v]), 32'd1);
      check(err[v] == (p == 0), "R8 err", 32'(err[v]), 32'(p == 0));
      check(rdata[v] === er[v], tag, rdata[v], er[v]);
    end
    if (w && p != 0) begin
      for (int v = 0; v < 3; v++) begin
        for (int i = 0; i < 2; i++)
          if ((HF[v] || HS[v]) && (!n || e[i])) mf[v][i] = d[20 + 2*i +: 2];
        if (HS[v]) msd[v] = d[31];
      end
    end
  endtask

  task automatic do_chk(logic [3:0] c, logic [1:0] p, bit h, bit s, bit n,
                        logic [1:0] e, string tag);
    @(negedge clk);
    cpn = c; pl = p; hyp = h; simd = s; ns = n; ns_en = e;
    #1;
    for (int v = 0; v < 3; v++)
      check(undef[v] == exp_undef(v), tag, 32'(undef[v]), 32'(exp_undef(v)));
  endtask

  initial begin
    for (int k = 0; k < 50000; k++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req = 0; we = 0; wdata = '0; pl = 2'd1; ns = 0; ns_en = 2'b00;
    cpn = 4'd0; hyp = 0; simd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int v = 0; v < 3; v++) begin
      check(ack[v] == 0 && err[v] == 0, "R1 idle after reset",
            32'({ack[v], err[v]}), 32'd0);
      check(rdata[v] == 0, "R1 rdata after reset", rdata[v], 32'd0);
    end
    do_acc(0, '0, 2'd1, 0, 2'b00, "R1 reset read");

    // reserved and read-only bits
    do_acc(1, 32'hFFFF_FFFF, 2'd1, 0, 2'b00, "R7 write ones");
    do_acc(0, '0, 2'd1, 0, 2'b00, "R7 R5 R6 read after ones");
    // clear bit 31 attempt: only writable instance follows
    do_acc(1, 32'h0000_0000, 2'd3, 0, 2'b00, "R5 write zeros");
    do_acc(0, '0, 2'd2, 0, 2'b00, "R5 R6 read after zeros");

    // slot 10 = 01, slot 11 = 11
    do_acc(1, 32'h00D0_0000, 2'd1, 0, 2'b00, "R2 set codes");
    do_chk(4'd10, 2'd0, 0, 0, 0, 2'b00, "R2 code01 at pl0");
    do_chk(4'd10, 2'd1, 0, 0, 0, 2'b00, "R2 code01 at pl1");
    do_chk(4'd11, 2'd0, 0, 0, 0, 2'b00, "R11 slot11 independent");
    do_chk(4'd9,  2'd0, 0, 0, 0, 2'b00, "R11 other cp");
    do_chk(4'd10, 2'd0, 1, 1, 0, 2'b00, "R9 hyp bypass");
    // PL0 write rejected
    do_acc(1, 32'h0000_0000, 2'd0, 0, 2'b00, "R8 pl0 write");
    do_acc(0, '0, 2'd0, 0, 2'b00, "R8 pl0 read");
    do_acc(0, '0, 2'd1, 0, 2'b00, "R8 word kept");
    // reserved code on slot 10
    do_acc(1, 32'h00E0_0000, 2'd1, 0, 2'b00, "R3 set code10");
    do_chk(4'd10, 2'd1, 0, 0, 0, 2'b00, "R3 reserved denies");
    // SIMD disable
    do_acc(1, 32'h80F0_0000, 2'd1, 0, 2'b00, "R4 set disable");
    do_chk(4'd11, 2'd1, 0, 1, 0, 2'b00, "R4 simd blocked");
    do_chk(4'd11, 2'd1, 0, 0, 0, 2'b00, "R4 fp allowed");
    do_acc(1, 32'h00F0_0000, 2'd1, 0, 2'b00, "R4 clear disable");
    do_chk(4'd10, 2'd0, 0, 1, 0, 2'b00, "R4 R5 simd after clear");
    // Non-secure masking
    do_acc(1, 32'h0000_0000, 2'd1, 1, 2'b01, "R10 ns partial write");
    do_acc(0, '0, 2'd1, 1, 2'b01, "R10 ns masked read");
    do_acc(0, '0, 2'd1, 0, 2'b00, "R10 secure view");
    do_chk(4'd11, 2'd1, 0, 0, 1, 2'b01, "R10 ns masked check");
    do_chk(4'd11, 2'd1, 0, 0, 1, 2'b10, "R10 ns enabled check");

    for (int k = 0; k < 600; k++) begin
      if ($urandom % 2 == 0) begin
        do_acc(1'($urandom), $urandom, 2'($urandom), 1'($urandom),
               2'($urandom), "R7 R10 R12 random access");
      end else begin
        logic [3:0] c;
        c = ($urandom % 4 == 0) ? 4'($urandom) : 4'(10 + $urandom % 2);
        do_chk(c, 2'($urandom), ($urandom % 6 == 0), 1'($urandom),
               1'($urandom), 2'($urandom), "R2 R3 R4 R11 random check");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule